// File: doc/BRIEF.md
# Peripheral Request to Channel Router

This block sits between a set of numbered peripheral request lines and the channels of a transfer controller. Software programs a routing table over a simple register bus. The table has one entry per request line, and each entry names the channel that the line feeds. Every cycle the router collects the active lines for each channel and drives a registered per-channel request vector toward the channel engines. It neither moves data nor arbitrates between channels.

A channel that no peripheral serves can be started by software. Writing a one to bit 0 of that channel's request register produces a single request pulse. A status register reads back the forwarded request vector. Request line n is `req_in[n-1]`, and its table entry is addressed by n. Number zero is kept for software-only use and has no table entry.

Top module: `dreq_router`

## Requirements
- R1: After a synchronous reset, every table entry is zero, `chan_req` is all zero, no software request is pending, and `bus_rdata` is zero.
- R2: The entry for request line n (1 to NUM_REQ) is at byte address 0x2000 + 4*(n-1). A write stores the low ENT_W bits of `bus_wdata`, where ENT_W = clog2(NUM_CHN+1). A read returns them in `bus_rdata[ENT_W-1:0]` with all upper bits zero.
- R3: When entry n holds v with 1 <= v <= NUM_CHN, `req_in[n-1]` drives `chan_req[v-1]`. The output is registered: the value of `req_in` sampled at a clock edge appears on `chan_req` just after that edge.
- R4: An entry holding zero connects its request line to no channel.
- R5: An entry holding a value above NUM_CHN connects its request line to no channel.
- R6: When several entries name the same channel, that channel's request is the OR of their lines.
- R7: Writing a word with bit 0 set to byte address 0x1000 + 0x40*c + 0x4 raises `chan_req[c]` for exactly one cycle. The pulse is seen two clock edges after the write edge. A write to that address with bit 0 clear has no effect. A read of that address returns the pending bit in bit 0, which is clear once the pulse has been issued.
- R8: A read of byte address 0x0008 returns the current `chan_req` vector in `bus_rdata[NUM_CHN-1:0]`.
- R9: Read data is registered and valid just after the edge that samples `bus_rd`. In cycles without a read, and for unmapped or misaligned addresses, it is zero. Writes to unmapped or misaligned addresses change nothing.
- R10: A table write at one edge is already used to route the requests sampled at the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | ADDR_W | Byte address |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Registered read data |
| req_in | input | NUM_REQ | Peripheral request lines, line n on bit n-1 |
| chan_req | output | NUM_CHN | Registered per-channel request vector |

## Verification
The hardest case to reach from the ports is the one where the table changes while requests stay asserted. Here the edge that retires an entry must also stop routing the line, with no stale cycle. The stimulus walks every entry through every storable value, including the out-of-range codes. It keeps the line asserted across the write back to zero and samples the cycle just after that write. A second phase packs several lines onto shared channels and changes the request pattern on every cycle, so the OR merging is checked against a model of the table held by the bench.

// File: rtl/dreq_router_pkg.sv
package dreq_router_pkg;

  typedef enum logic [1:0] {
    SEL_NONE   = 2'd0,
    SEL_TABLE  = 2'd1,
    SEL_SWREQ  = 2'd2,
    SEL_STATUS = 2'd3
  } sel_e;

  typedef struct packed {
    sel_e        sel;
    logic [15:0] idx;
  } dec_t;

  localparam logic [31:0] TBL_BASE   = 32'h0000_2000;
  localparam logic [31:0] CHN_BASE   = 32'h0000_1000;
  localparam int          CHN_STRIDE = 64;
  localparam logic [31:0] SW_OFS     = 32'h0000_0004;
  localparam logic [31:0] STAT_ADDR  = 32'h0000_0008;

endpackage

// File: rtl/dreq_addr_decode.sv
module dreq_addr_decode
  import dreq_router_pkg::*;
#(
  parameter int ADDR_W  = 14,
  parameter int NUM_REQ = 16,
  parameter int NUM_CHN = 8
) (
  input  logic [ADDR_W-1:0] addr,
  output dec_t              dec
);
  localparam logic [31:0] TBL_HI   = 32'(TBL_BASE + 32'(4 * NUM_REQ));
  localparam logic [31:0] CHN_HI   = 32'(CHN_BASE + 32'(CHN_STRIDE * NUM_CHN));
  localparam logic [31:0] WIN_MASK = 32'(CHN_STRIDE - 1);
  localparam int          WIN_SH   = $clog2(CHN_STRIDE);

  logic [31:0] a;
  assign a = {{(32-ADDR_W){1'b0}}, addr};

  always_comb begin
    dec.sel = SEL_NONE;
    dec.idx = '0;
    if (a[1:0] == 2'b00) begin
      if (a >= TBL_BASE && a < TBL_HI) begin
        dec.sel = SEL_TABLE;
        dec.idx = 16'((a - TBL_BASE) >> 2);
      end else if (a >= CHN_BASE && a < CHN_HI &&
                   ((a - CHN_BASE) & WIN_MASK) == SW_OFS) begin
        dec.sel = SEL_SWREQ;
        dec.idx = 16'((a - CHN_BASE) >> WIN_SH);
      end else if (a == STAT_ADDR) begin
        dec.sel = SEL_STATUS;
      end
    end
  end
endmodule

// File: rtl/dreq_map_table.sv
module dreq_map_table #(
  parameter int NUM_REQ = 16,
  parameter int ENT_W   = 4,
  localparam int IDX_W  = (NUM_REQ > 1) ? $clog2(NUM_REQ) : 1
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     wr_en,
  input  logic [IDX_W-1:0]         wr_idx,
  input  logic [ENT_W-1:0]         wr_val,
  input  logic [IDX_W-1:0]         rd_idx,
  output logic [ENT_W-1:0]         rd_val,
  output logic [NUM_REQ*ENT_W-1:0] entries
);
  logic [ENT_W-1:0] mem [NUM_REQ];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NUM_REQ; i++) mem[i] <= '0;
    end else if (wr_en) begin
      mem[wr_idx] <= wr_val;
    end
  end

  assign rd_val = mem[rd_idx];

  for (genvar g = 0; g < NUM_REQ; g++) begin : g_flat
    assign entries[g*ENT_W +: ENT_W] = mem[g];
  end
endmodule

// File: rtl/dreq_sw_trigger.sv
module dreq_sw_trigger #(
  parameter int NUM_CHN = 8,
  localparam int CIDX_W = (NUM_CHN > 1) ? $clog2(NUM_CHN) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              set_en,
  input  logic [CIDX_W-1:0] set_idx,
  output logic [NUM_CHN-1:0] pend
);
  for (genvar c = 0; c < NUM_CHN; c++) begin : g_chn
    always_ff @(posedge clk) begin
      if (rst) pend[c] <= 1'b0;
      else     pend[c] <= set_en && (set_idx == CIDX_W'(c));
    end
  end
endmodule

// File: rtl/dreq_fanout.sv
module dreq_fanout #(
  parameter int NUM_REQ = 16,
  parameter int NUM_CHN = 8,
  parameter int ENT_W   = 4
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic [NUM_REQ*ENT_W-1:0] entries,
  input  logic [NUM_REQ-1:0]       req_in,
  input  logic [NUM_CHN-1:0]       sw_pulse,
  output logic [NUM_CHN-1:0]       chan_req
);
  logic [NUM_CHN-1:0] mapped;

  for (genvar c = 0; c < NUM_CHN; c++) begin : g_chn
    logic [NUM_REQ-1:0] match;
    for (genvar r = 0; r < NUM_REQ; r++) begin : g_line
      assign match[r] = (entries[r*ENT_W +: ENT_W] == ENT_W'(c + 1));
    end
    assign mapped[c] = |match;

    always_ff @(posedge clk) begin
      if (rst) chan_req[c] <= 1'b0;
      else     chan_req[c] <= (|(match & req_in)) | sw_pulse[c];
    end

    p_unmapped_chan_r4: assert property (@(posedge clk) disable iff (rst)
      (!$past(mapped[c]) && !$past(sw_pulse[c])) |-> !chan_req[c]);
  end

  p_idle_quiet_r3: assert property (@(posedge clk) disable iff (rst)
    ($past(req_in) == '0 && $past(sw_pulse) == '0) |-> (chan_req == '0));
endmodule

// File: rtl/dreq_router.sv
module dreq_router
  import dreq_router_pkg::*;
#(
  parameter int NUM_REQ = 16,
  parameter int NUM_CHN = 8,
  parameter int ADDR_W  = 14,
  parameter int DATA_W  = 32
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               bus_wr,
  input  logic               bus_rd,
  input  logic [ADDR_W-1:0]  bus_addr,
  input  logic [DATA_W-1:0]  bus_wdata,
  output logic [DATA_W-1:0]  bus_rdata,
  input  logic [NUM_REQ-1:0] req_in,
  output logic [NUM_CHN-1:0] chan_req
);
  localparam int ENT_W  = $clog2(NUM_CHN + 1);
  localparam int IDX_W  = (NUM_REQ > 1) ? $clog2(NUM_REQ) : 1;
  localparam int CIDX_W = (NUM_CHN > 1) ? $clog2(NUM_CHN) : 1;

  dec_t                     dec;
  logic [ENT_W-1:0]         tbl_rd_val;
  logic [NUM_REQ*ENT_W-1:0] entries;
  logic [NUM_CHN-1:0]       pend;
  logic                     tbl_wr;
  logic                     sw_set;

  assign tbl_wr = bus_wr && (dec.sel == SEL_TABLE);
  assign sw_set = bus_wr && (dec.sel == SEL_SWREQ) && bus_wdata[0];

  dreq_addr_decode #(.ADDR_W(ADDR_W), .NUM_REQ(NUM_REQ), .NUM_CHN(NUM_CHN)) u_dec (
    .addr (bus_addr),
    .dec  (dec)
  );

  dreq_map_table #(.NUM_REQ(NUM_REQ), .ENT_W(ENT_W)) u_tbl (
    .clk     (clk),
    .rst     (rst),
    .wr_en   (tbl_wr),
    .wr_idx  (dec.idx[IDX_W-1:0]),
    .wr_val  (bus_wdata[ENT_W-1:0]),
    .rd_idx  (dec.idx[IDX_W-1:0]),
    .rd_val  (tbl_rd_val),
    .entries (entries)
  );

  dreq_sw_trigger #(.NUM_CHN(NUM_CHN)) u_sw (
    .clk     (clk),
    .rst     (rst),
    .set_en  (sw_set),
    .set_idx (dec.idx[CIDX_W-1:0]),
    .pend    (pend)
  );

  dreq_fanout #(.NUM_REQ(NUM_REQ), .NUM_CHN(NUM_CHN), .ENT_W(ENT_W)) u_fan (
    .clk      (clk),
    .rst      (rst),
    .entries  (entries),
    .req_in   (req_in),
    .sw_pulse (pend),
    .chan_req (chan_req)
  );

  always_ff @(posedge clk) begin
    if (rst || !bus_rd) begin
      bus_rdata <= '0;
    end else begin
      unique case (dec.sel)
        SEL_TABLE:  bus_rdata <= DATA_W'(tbl_rd_val);
        SEL_SWREQ:  bus_rdata <= DATA_W'(pend[dec.idx[CIDX_W-1:0]]);
        SEL_STATUS: bus_rdata <= DATA_W'(chan_req);
        default:    bus_rdata <= '0;
      endcase
    end
  end

  logic unused_bits;
  assign unused_bits = ^{bus_wdata, dec.idx};

  for (genvar c = 0; c < NUM_CHN; c++) begin : g_chk
    p_sw_pulse_r7: assert property (@(posedge clk) disable iff (rst)
      (sw_set && dec.idx[CIDX_W-1:0] == CIDX_W'(c)) |=> ##1 chan_req[c]);
  end

  p_status_read_r8: assert property (@(posedge clk) disable iff (rst)
    (bus_rd && dec.sel == SEL_STATUS) |=> (bus_rdata == DATA_W'($past(chan_req))));

  p_rdata_idle_r9: assert property (@(posedge clk) disable iff (rst)
    !bus_rd |=> (bus_rdata == '0));
endmodule

// File: tb/sim_dreq_router.sv
module sim_dreq_router;
  localparam int NREQ = 16;
  localparam int NCHN = 8;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        bus_wr = 1'b0, bus_rd = 1'b0;
  logic [13:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [NREQ-1:0] req_in = '0;
  logic [NCHN-1:0] chan_req;

  int total = 0, fails = 0;
  bit done = 0;
  int mdl [1:NREQ];

  always #10 clk = ~clk;

  dreq_router #(.NUM_REQ(NREQ), .NUM_CHN(NCHN)) u0 (
    .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .req_in(req_in), .chan_req(chan_req)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [13:0] a, input logic [31:0] d);
    @(negedge clk); bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk); bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [13:0] a, output logic [31:0] d);
    @(negedge clk); bus_rd = 1'b1; bus_addr = a;
    @(negedge clk); bus_rd = 1'b0; d = bus_rdata;
  endtask

  function automatic logic [13:0] ent_addr(input int n);
    return 14'(32'h2000 + 4 * (n - 1));
  endfunction

  function automatic logic [NCHN-1:0] route(input logic [NREQ-1:0] r);
    logic [NCHN-1:0] e = '0;
    for (int n = 1; n <= NREQ; n++)
      if (r[n-1] && mdl[n] >= 1 && mdl[n] <= NCHN) e[mdl[n]-1] = 1'b1;
    return e;
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++; total++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    logic [NREQ-1:0] pat;
    for (int n = 1; n <= NREQ; n++) mdl[n] = 0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk("R1 chan_req after reset", 32'(chan_req), 0);
    chk("R1 rdata after reset", bus_rdata, 0);
    rd(ent_addr(1), d);  chk("R1 entry1 after reset", d, 0);
    rd(14'h1004, d);     chk("R1 sw pending after reset", d, 0);

    // R2 R3 R4 R5 R10: every entry through every storable value
    for (int n = 1; n <= NREQ; n++) begin
      for (int v = 0; v < 16; v++) begin
        logic [NCHN-1:0] e;
        e = (v >= 1 && v <= NCHN) ? NCHN'(1 << (v - 1)) : '0;
        wr(ent_addr(n), 32'(v) | 32'h0000_0F30);
        rd(ent_addr(n), d);
        chk("R2 entry readback", d, 32'(v));
        req_in = NREQ'(1 << (n - 1));
        @(negedge clk);
        chk((v > NCHN) ? "R5 out of range entry" : (v == 0 ? "R4 zero entry" : "R3 routed line"),
            32'(chan_req), 32'(e));
        wr(ent_addr(n), 0);
        @(negedge clk);
        chk("R10 R4 cleared entry stops route", 32'(chan_req), 0);
        req_in = '0;
      end
    end

    // R6: shared channels, changing pattern every cycle
    for (int n = 1; n <= NREQ; n++) begin
      mdl[n] = (n * 5) % 10;
      wr(ent_addr(n), 32'(mdl[n]));
    end
    pat = 16'hACE1;
    for (int k = 0; k < 40; k++) begin
      @(negedge clk);
      if (k > 0) chk("R6 merged channel request", 32'(chan_req), 32'(route(req_in)));
      pat = {pat[14:0], pat[15] ^ pat[13] ^ pat[12] ^ pat[10]};
      req_in = pat;
    end
    req_in = '1;
    @(negedge clk);
    chk("R6 all lines", 32'(chan_req), 32'(route('1)));

    // R8: status readback
    foreach (mdl[n]) begin end
    for (int k = 0; k < 4; k++) begin
      req_in = NREQ'(16'h1234 * (k + 3));
      @(negedge clk);
      rd(14'h0008, d);
      chk("R8 status register", d, 32'(route(req_in)));
    end
    req_in = '0;
    @(negedge clk); @(negedge clk);

    // R7: software trigger per channel
    for (int c = 0; c < NCHN; c++) begin
      wr(14'(32'h1000 + 64 * c + 4), 32'h1);
      chk("R7 no pulse yet", 32'(chan_req), 0);
      @(negedge clk);
      chk("R7 pulse cycle", 32'(chan_req), 32'(1 << c));
      @(negedge clk);
      chk("R7 pulse ends", 32'(chan_req), 0);
      rd(14'(32'h1000 + 64 * c + 4), d);
      chk("R7 pending self cleared", d, 0);
    end
    wr(14'h1044, 32'h2);
    @(negedge clk);
    chk("R7 bit0 clear ignored", 32'(chan_req), 0);
    @(negedge clk);
    chk("R7 bit0 clear ignored later", 32'(chan_req), 0);

    // R9: unmapped and misaligned accesses
    rd(14'h0000, d); chk("R9 unmapped read 0x0", d, 0);
    rd(14'(32'h2000 + 4 * NREQ), d); chk("R9 read past table", d, 0);
    rd(14'h1000, d); chk("R9 window offset 0 read", d, 0);
    rd(14'h2002, d); chk("R9 misaligned read", d, 0);
    wr(14'h2001, 32'h7);
    rd(ent_addr(1), d); chk("R9 misaligned write ignored", d, 32'(mdl[1]));
    wr(14'h1000, 32'h1);
    @(negedge clk);
    chk("R9 wrong window offset no pulse", 32'(chan_req), 0);
    @(negedge clk);
    chk("R9 wrong window offset no pulse later", 32'(chan_req), 0);
    @(negedge clk);
    chk("R9 rdata idle", bus_rdata, 0);

    done = 1;
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule